// File: doc/BRIEF.md
# Tagged Floating-Point Register Stack

This block holds the eight working registers of a floating-point unit as a circular stack of 80-bit extended-precision values. Software addresses registers relative to a 3-bit top pointer, so ST(i) is the physical slot (top + i) mod 8. Each physical slot carries a 2-bit tag that tells whether the slot holds a normal value, a zero, a special value, or nothing. Tags let a slot be released without touching its data, and the pointer can be moved with no data transfer at all.

One command is accepted per clock: push, pop, increment or decrement the pointer, free a register, exchange ST with another register, write a register, write a register and then pop, or initialize. Two combinational read ports return ST(i) and ST(j) with an empty indication each, and a third index reports the tag of any relative register. Stack overflow and underflow are reported as one-cycle pulses in the cycle after the offending command. The pointer and all tags are exported so that status and tag words can be built by neighbouring logic.

The controller decodes each command in a single `unique case` with no multi-cycle states: every command completes at the clock edge that samples it. Its only state is the top pointer, the tag array and the two flag registers.

Top module: `fprs_stack`

## Requirements
- R1: While `rst_n` is low and after its release, the top pointer is 0, every tag is 11 (empty), and `overflow_o` and `underflow_o` are low.
- R2: Push (code 1) lowers the top pointer by one modulo 8 and writes `wdata_i` into the slot it then points at; the new ST is the pushed value and the previous ST becomes ST(1).
- R3: Every write sets the slot's tag from the value (sign bit 79, exponent bits 78:64, integer bit 63, fraction 62:0): 01 zero when exponent and bits 63:0 are all zero; 10 special when the exponent is all ones, or the exponent is zero with a nonzero significand, or the exponent is nonzero with bit 63 clear; 00 valid otherwise. Tag 11 means empty.
- R4: Pop (code 2) on a non-empty ST sets the tag of ST to empty and then raises the top pointer by one modulo 8; register data is unchanged.
- R5: Increment (code 3) and decrement (code 4) move only the top pointer, 7 to 0 and 0 to 7 respectively, with no change to any tag or data.
- R6: Free (code 5) sets the tag of ST(`idx_i`) to empty and leaves that register's data readable and unchanged.
- R7: Exchange (code 6) swaps data and tags of ST and ST(`idx_i`); an index of 0 selects ST(1).
- R8: Write (code 7) stores `wdata_i` into ST(`idx_i`) with its class tag, whatever the previous tag, and leaves the pointer unchanged.
- R9: Write-and-pop (code 8) stores `wdata_i` into ST(`idx_i`) and then pops ST, so the former ST(`idx_i`) becomes ST(`idx_i`-1).
- R10: A push whose target slot is not empty leaves pointer, tags and data unchanged and raises `overflow_o` for the one cycle after the command.
- R11: Pop, exchange or write-and-pop with an empty operand slot (ST, or ST(i) for exchange) leaves the stack unchanged and raises `underflow_o` for the one cycle after the command; each read port raises its empty output while its register's tag is 11.
- R12: Initialize (code 9) sets the top pointer to 0 and every tag to empty and keeps all register data.
- R13: `rd_a_data_o`, `rd_b_data_o` and `tag_o` address physical slot (top + index) mod 8; `tag_word_o` bits 2k+1:2k hold the tag of physical slot k and `top_o` is the pointer.
- R14: Code 0 and codes 10 to 15 change nothing and raise no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_i | input | 4 | Command code |
| idx_i | input | 3 | Relative register index for free, exchange, write, write-and-pop |
| wdata_i | input | 80 | Value for push, write, write-and-pop |
| rd_a_idx_i | input | 3 | Relative index of read port A |
| rd_a_data_o | output | 80 | Contents of ST(rd_a_idx_i) |
| rd_a_empty_o | output | 1 | Tag of ST(rd_a_idx_i) is empty |
| rd_b_idx_i | input | 3 | Relative index of read port B |
| rd_b_data_o | output | 80 | Contents of ST(rd_b_idx_i) |
| rd_b_empty_o | output | 1 | Tag of ST(rd_b_idx_i) is empty |
| tag_idx_i | input | 3 | Relative index for the tag query |
| tag_o | output | 2 | Tag of ST(tag_idx_i) |
| top_o | output | 3 | Top-of-stack pointer |
| tag_word_o | output | 16 | All tags, physical slot order |
| overflow_o | output | 1 | Push hit a non-empty slot (one-cycle pulse) |
| underflow_o | output | 1 | Operand slot was empty (one-cycle pulse) |

## Verification
The assertions take for granted that `cmd_i` and `idx_i` are never unknown in a cycle after reset release, and that reset is applied before the first command, so the pointer and tags they compare against `$past` values are always defined. They also presume a power-of-two depth, which makes the pointer wrap fall out of plain binary arithmetic. The stimulus changes every input only on falling edges, drives NOP between commands, and uses unlisted codes only in the one scenario that checks they are ignored.

// File: rtl/fprs_pkg.sv
package fprs_pkg;

    localparam int FPRS_DATA_W = 80;
    localparam int FPRS_EXP_W  = 15;
    localparam int FPRS_DEPTH  = 8;

    typedef enum logic [3:0] {
        CMD_NOP   = 4'd0,
        CMD_PUSH  = 4'd1,
        CMD_POP   = 4'd2,
        CMD_INC   = 4'd3,
        CMD_DEC   = 4'd4,
        CMD_FREE  = 4'd5,
        CMD_XCHG  = 4'd6,
        CMD_WRITE = 4'd7,
        CMD_WRPOP = 4'd8,
        CMD_INIT  = 4'd9
    } cmd_e;

    typedef enum logic [1:0] {
        TAG_VALID   = 2'b00,
        TAG_ZERO    = 2'b01,
        TAG_SPECIAL = 2'b10,
        TAG_EMPTY   = 2'b11
    } tag_e;

endpackage

// File: rtl/fprs_classify.sv
module fprs_classify
    import fprs_pkg::*;
#(
    parameter int DATA_W = FPRS_DATA_W,
    parameter int EXP_W  = FPRS_EXP_W,
    localparam int MAN_W = DATA_W - 1 - EXP_W
) (
    input  logic [DATA_W-2:0] mag_i,
    output logic [1:0]        tag_o
);

    logic [EXP_W-1:0] exp_f;
    logic [MAN_W-1:0] man_f;
    logic             exp_ones;
    logic             exp_zero;
    logic             man_zero;

    assign exp_f    = mag_i[DATA_W-2 -: EXP_W];
    assign man_f    = mag_i[MAN_W-1:0];
    assign exp_ones = &exp_f;
    assign exp_zero = ~|exp_f;
    assign man_zero = ~|man_f;

    always_comb begin
        if (exp_zero && man_zero) begin
            tag_o = TAG_ZERO;
        end else if (exp_ones || exp_zero || !man_f[MAN_W-1]) begin
            tag_o = TAG_SPECIAL;
        end else begin
            tag_o = TAG_VALID;
        end
    end

    always_comb begin
        a_r3_empty_never_written: assert (tag_o != TAG_EMPTY);
    end

endmodule

// File: rtl/fprs_regfile.sv
module fprs_regfile
    import fprs_pkg::*;
#(
    parameter int DATA_W = FPRS_DATA_W,
    parameter int DEPTH  = FPRS_DEPTH,
    localparam int PW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [PW-1:0]     wr_slot_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              swap_en_i,
    input  logic [PW-1:0]     swap_p_i,
    input  logic [PW-1:0]     swap_q_i,
    input  logic [PW-1:0]     ra_slot_i,
    output logic [DATA_W-1:0] ra_data_o,
    input  logic [PW-1:0]     rb_slot_i,
    output logic [DATA_W-1:0] rb_data_o
);

    logic [DEPTH-1:0][DATA_W-1:0] mem_q;

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mem_q[g] <= '0;
            end else if (swap_en_i && swap_p_i == PW'(g)) begin
                mem_q[g] <= mem_q[swap_q_i];
            end else if (swap_en_i && swap_q_i == PW'(g)) begin
                mem_q[g] <= mem_q[swap_p_i];
            end else if (wr_en_i && wr_slot_i == PW'(g)) begin
                mem_q[g] <= wr_data_i;
            end
        end
    end

    assign ra_data_o = mem_q[ra_slot_i];
    assign rb_data_o = mem_q[rb_slot_i];

    a_r7_swap_moves_data: assert property (@(posedge clk) disable iff (!rst_n)
        (swap_en_i && swap_p_i != swap_q_i) |=>
            (mem_q[$past(swap_p_i)] == $past(mem_q[swap_q_i]) &&
             mem_q[$past(swap_q_i)] == $past(mem_q[swap_p_i])));

    a_r8_single_writer: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en_i && swap_en_i));

endmodule

// File: rtl/fprs_ctrl.sv
module fprs_ctrl
    import fprs_pkg::*;
#(
    parameter int DEPTH = FPRS_DEPTH,
    localparam int PW   = $clog2(DEPTH)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  cmd_e                  cmd_i,
    input  logic [PW-1:0]         idx_i,
    input  logic [1:0]            wtag_i,
    output logic [PW-1:0]         top_o,
    output logic [DEPTH-1:0][1:0] tags_o,
    output logic                  wr_en_o,
    output logic [PW-1:0]         wr_slot_o,
    output logic                  swap_en_o,
    output logic [PW-1:0]         swap_p_o,
    output logic [PW-1:0]         swap_q_o,
    output logic                  overflow_o,
    output logic                  underflow_o
);

    logic [PW-1:0]         top_q, top_d;
    logic [DEPTH-1:0][1:0] tag_q, tag_d;
    logic                  ovf_q, ovf_d;
    logic                  unf_q, unf_d;

    logic [PW-1:0] slot_rel;
    logic [PW-1:0] slot_xch;
    logic [PW-1:0] slot_push;
    logic [PW-1:0] xch_idx;
    logic          st_empty;

    assign slot_rel  = top_q + idx_i;
    assign xch_idx   = (idx_i == '0) ? PW'(1) : idx_i;
    assign slot_xch  = top_q + xch_idx;
    assign slot_push = top_q - 1'b1;
    assign st_empty  = (tag_q[top_q] == TAG_EMPTY);

    always_comb begin
        top_d     = top_q;
        tag_d     = tag_q;
        ovf_d     = 1'b0;
        unf_d     = 1'b0;
        wr_en_o   = 1'b0;
        wr_slot_o = slot_rel;
        swap_en_o = 1'b0;
        swap_p_o  = top_q;
        swap_q_o  = slot_xch;
        unique case (cmd_i)
            CMD_PUSH: begin
                if (tag_q[slot_push] != TAG_EMPTY) begin
                    ovf_d = 1'b1;
                end else begin
                    top_d            = slot_push;
                    tag_d[slot_push] = wtag_i;
                    wr_en_o          = 1'b1;
                    wr_slot_o        = slot_push;
                end
            end
            CMD_POP: begin
                if (st_empty) begin
                    unf_d = 1'b1;
                end else begin
                    tag_d[top_q] = TAG_EMPTY;
                    top_d        = top_q + 1'b1;
                end
            end
            CMD_INC: top_d = top_q + 1'b1;
            CMD_DEC: top_d = top_q - 1'b1;
            CMD_FREE: tag_d[slot_rel] = TAG_EMPTY;
            CMD_XCHG: begin
                if (st_empty || tag_q[slot_xch] == TAG_EMPTY) begin
                    unf_d = 1'b1;
                end else begin
                    tag_d[top_q]    = tag_q[slot_xch];
                    tag_d[slot_xch] = tag_q[top_q];
                    swap_en_o       = 1'b1;
                end
            end
            CMD_WRITE: begin
                tag_d[slot_rel] = wtag_i;
                wr_en_o         = 1'b1;
            end
            CMD_WRPOP: begin
                if (st_empty) begin
                    unf_d = 1'b1;
                end else begin
                    tag_d[slot_rel] = wtag_i;
                    tag_d[top_q]    = TAG_EMPTY;
                    top_d           = top_q + 1'b1;
                    wr_en_o         = 1'b1;
                end
            end
            CMD_INIT: begin
                top_d = '0;
                for (int k = 0; k < DEPTH; k++) begin
                    tag_d[k] = TAG_EMPTY;
                end
            end
            default: begin
                top_d = top_q;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            top_q <= '0;
            tag_q <= '1;
            ovf_q <= 1'b0;
            unf_q <= 1'b0;
        end else begin
            top_q <= top_d;
            tag_q <= tag_d;
            ovf_q <= ovf_d;
            unf_q <= unf_d;
        end
    end

    assign top_o       = top_q;
    assign tags_o      = tag_q;
    assign overflow_o  = ovf_q;
    assign underflow_o = unf_q;

    a_r10_push_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == CMD_PUSH && tag_q[slot_push] != TAG_EMPTY) |=>
            (ovf_q && $stable(top_q) && $stable(tag_q)));

    a_r11_pop_empty_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == CMD_POP && st_empty) |=> (unf_q && $stable(top_q) && $stable(tag_q)));

    a_r4_pop_frees_top: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == CMD_POP && !st_empty) |=>
            (top_q == $past(top_q) + 1'b1 && tag_q[$past(top_q)] == TAG_EMPTY));

    a_r5_dec_moves_only_top: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == CMD_DEC) |=> (top_q == $past(top_q) - 1'b1 && $stable(tag_q)));

    a_r5_inc_moves_only_top: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == CMD_INC) |=> (top_q == $past(top_q) + 1'b1 && $stable(tag_q)));

    a_r12_init_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == CMD_INIT) |=> (top_q == '0 && (&tag_q)));

    a_r6_free_keeps_top: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == CMD_FREE) |=> ($stable(top_q) && !ovf_q && !unf_q));

endmodule

// File: rtl/fprs_stack.sv
module fprs_stack
    import fprs_pkg::*;
#(
    parameter int DATA_W = FPRS_DATA_W,
    parameter int EXP_W  = FPRS_EXP_W,
    parameter int DEPTH  = FPRS_DEPTH,
    localparam int PW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        cmd_i,
    input  logic [PW-1:0]     idx_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [PW-1:0]     rd_a_idx_i,
    output logic [DATA_W-1:0] rd_a_data_o,
    output logic              rd_a_empty_o,
    input  logic [PW-1:0]     rd_b_idx_i,
    output logic [DATA_W-1:0] rd_b_data_o,
    output logic              rd_b_empty_o,
    input  logic [PW-1:0]     tag_idx_i,
    output logic [1:0]        tag_o,
    output logic [PW-1:0]     top_o,
    output logic [2*DEPTH-1:0] tag_word_o,
    output logic              overflow_o,
    output logic              underflow_o
);

    logic [1:0]            wtag;
    logic [PW-1:0]         top;
    logic [DEPTH-1:0][1:0] tags;
    logic                  wr_en;
    logic [PW-1:0]         wr_slot;
    logic                  swap_en;
    logic [PW-1:0]         swap_p;
    logic [PW-1:0]         swap_q;
    logic [PW-1:0]         ra_slot;
    logic [PW-1:0]         rb_slot;
    logic [PW-1:0]         tq_slot;

    fprs_classify #(
        .DATA_W (DATA_W),
        .EXP_W  (EXP_W)
    ) u_classify (
        .mag_i (wdata_i[DATA_W-2:0]),
        .tag_o (wtag)
    );

    fprs_ctrl #(
        .DEPTH (DEPTH)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_i       (cmd_e'(cmd_i)),
        .idx_i       (idx_i),
        .wtag_i      (wtag),
        .top_o       (top),
        .tags_o      (tags),
        .wr_en_o     (wr_en),
        .wr_slot_o   (wr_slot),
        .swap_en_o   (swap_en),
        .swap_p_o    (swap_p),
        .swap_q_o    (swap_q),
        .overflow_o  (overflow_o),
        .underflow_o (underflow_o)
    );

    assign ra_slot = top + rd_a_idx_i;
    assign rb_slot = top + rd_b_idx_i;
    assign tq_slot = top + tag_idx_i;

    fprs_regfile #(
        .DATA_W (DATA_W),
        .DEPTH  (DEPTH)
    ) u_regfile (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en),
        .wr_slot_i (wr_slot),
        .wr_data_i (wdata_i),
        .swap_en_i (swap_en),
        .swap_p_i  (swap_p),
        .swap_q_i  (swap_q),
        .ra_slot_i (ra_slot),
        .ra_data_o (rd_a_data_o),
        .rb_slot_i (rb_slot),
        .rb_data_o (rb_data_o_int)
    );

    logic [DATA_W-1:0] rb_data_o_int;
    assign rd_b_data_o = rb_data_o_int;

    assign rd_a_empty_o = (tags[ra_slot] == TAG_EMPTY);
    assign rd_b_empty_o = (tags[rb_slot] == TAG_EMPTY);
    assign tag_o        = tags[tq_slot];
    assign top_o        = top;
    assign tag_word_o   = tags;

    a_r11_flags_exclusive_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        overflow_o |=> !overflow_o || $past(cmd_i) == CMD_PUSH);

endmodule

// File: tb/fprs_stack_tb.sv
`timescale 1ns/1ps
module fprs_stack_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  cmd = 4'd0;
    logic [2:0]  idx = 3'd0;
    logic [79:0] wdata = '0;
    logic [2:0]  ra_idx = 3'd0;
    logic [79:0] ra_data;
    logic        ra_empty;
    logic [2:0]  rb_idx = 3'd0;
    logic [79:0] rb_data;
    logic        rb_empty;
    logic [2:0]  tq_idx = 3'd0;
    logic [1:0]  tq;
    logic [2:0]  top;
    logic [15:0] tword;
    logic        ovf;
    logic        unf;

    int n_tests = 0;
    int n_fail  = 0;

    localparam logic [79:0] V_ONE  = {1'b0, 15'h3FFF, 64'h8000_0000_0000_0000};
    localparam logic [79:0] V_NEG  = {1'b1, 15'h4000, 64'hC000_0000_0000_0000};
    localparam logic [79:0] V_ZERO = 80'h0;
    localparam logic [79:0] V_INF  = {1'b0, 15'h7FFF, 64'h8000_0000_0000_0000};
    localparam logic [79:0] V_DEN  = {1'b0, 15'h0000, 64'h0000_0000_0000_0001};
    localparam logic [79:0] V_UNN  = {1'b0, 15'h4000, 64'h4000_0000_0000_0000};
    localparam logic [79:0] V_W    = {1'b0, 15'h4001, 64'hA000_0000_0000_0000};

    always #4 clk = ~clk;

    fprs_stack u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_i        (cmd),
        .idx_i        (idx),
        .wdata_i      (wdata),
        .rd_a_idx_i   (ra_idx),
        .rd_a_data_o  (ra_data),
        .rd_a_empty_o (ra_empty),
        .rd_b_idx_i   (rb_idx),
        .rd_b_data_o  (rb_data),
        .rd_b_empty_o (rb_empty),
        .tag_idx_i    (tq_idx),
        .tag_o        (tq),
        .top_o        (top),
        .tag_word_o   (tword),
        .overflow_o   (ovf),
        .underflow_o  (unf)
    );

    task automatic chk(input string req, input logic [79:0] act, input logic [79:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [3:0] c, input logic [2:0] i, input logic [79:0] d);
        @(negedge clk);
        cmd   = c;
        idx   = i;
        wdata = d;
        @(negedge clk);
        cmd = 4'd0;
    endtask

    task automatic look(input logic [2:0] a, input logic [2:0] b, input logic [2:0] t);
        ra_idx = a;
        rb_idx = b;
        tq_idx = t;
        #1;
    endtask

    task automatic t_reset();
        look(3'd0, 3'd5, 3'd0);
        chk("R1 top", 80'(top), 80'd0);
        chk("R1 tags", 80'(tword), 80'hFFFF);
        chk("R1 ovf", 80'(ovf), 80'd0);
        chk("R1 unf", 80'(unf), 80'd0);
        chk("R11 empty read", 80'(ra_empty), 80'd1);
    endtask

    task automatic t_push();
        issue(4'd9, 3'd0, V_ZERO);
        issue(4'd1, 3'd0, V_ONE);
        look(3'd0, 3'd1, 3'd0);
        chk("R2 top after push", 80'(top), 80'd7);
        chk("R2 ST data", ra_data, V_ONE);
        chk("R3 valid tag", 80'(tq), 80'd0);
        chk("R13 tag word slot7", 80'(tword[15:14]), 80'd0);
        issue(4'd1, 3'd0, V_ZERO);
        look(3'd0, 3'd1, 3'd0);
        chk("R2 top second push", 80'(top), 80'd6);
        chk("R2 new ST", ra_data, V_ZERO);
        chk("R2 old ST now ST1", rb_data, V_ONE);
        chk("R3 zero tag", 80'(tq), 80'd1);
        issue(4'd1, 3'd0, V_INF);
        look(3'd0, 3'd0, 3'd0);
        chk("R3 inf special", 80'(tq), 80'd2);
        issue(4'd1, 3'd0, V_DEN);
        look(3'd0, 3'd0, 3'd0);
        chk("R3 denormal special", 80'(tq), 80'd2);
        issue(4'd1, 3'd0, V_UNN);
        look(3'd0, 3'd0, 3'd0);
        chk("R3 unnormal special", 80'(tq), 80'd2);
        issue(4'd1, 3'd0, V_NEG);
        look(3'd5, 3'd0, 3'd0);
        chk("R3 negative valid", 80'(tq), 80'd0);
        chk("R13 top after six", 80'(top), 80'd2);
        chk("R13 ST5 maps to slot7", ra_data, V_ONE);
    endtask

    task automatic t_xchg_write_free();
        issue(4'd9, 3'd0, V_ZERO);
        issue(4'd1, 3'd0, V_ONE);
        issue(4'd1, 3'd0, V_ZERO);
        issue(4'd1, 3'd0, V_INF);
        issue(4'd6, 3'd2, V_ZERO);
        look(3'd0, 3'd2, 3'd0);
        chk("R7 ST after xchg2", ra_data, V_ONE);
        chk("R7 ST2 after xchg2", rb_data, V_INF);
        chk("R7 ST tag moved", 80'(tq), 80'd0);
        look(3'd0, 3'd2, 3'd2);
        chk("R7 ST2 tag moved", 80'(tq), 80'd2);
        issue(4'd6, 3'd0, V_ZERO);
        look(3'd0, 3'd1, 3'd0);
        chk("R7 default index ST", ra_data, V_ZERO);
        chk("R7 default index ST1", rb_data, V_ONE);
        issue(4'd6, 3'd4, V_ZERO);
        look(3'd0, 3'd0, 3'd0);
        chk("R11 xchg empty unf", 80'(unf), 80'd1);
        chk("R11 xchg empty no change", ra_data, V_ZERO);
        issue(4'd7, 3'd3, V_NEG);
        look(3'd3, 3'd3, 3'd3);
        chk("R8 write empty slot data", ra_data, V_NEG);
        chk("R8 write tag", 80'(tq), 80'd0);
        chk("R8 not empty", 80'(ra_empty), 80'd0);
        chk("R8 top kept", 80'(top), 80'd5);
        issue(4'd5, 3'd3, V_ZERO);
        look(3'd3, 3'd3, 3'd3);
        chk("R6 free tag", 80'(tq), 80'd3);
        chk("R6 free keeps data", rb_data, V_NEG);
        chk("R6 read B empty", 80'(rb_empty), 80'd1);
    endtask

    task automatic t_incdec_init();
        issue(4'd9, 3'd0, V_ZERO);
        issue(4'd1, 3'd0, V_ONE);
        issue(4'd9, 3'd0, V_ZERO);
        look(3'd7, 3'd0, 3'd0);
        chk("R12 init top", 80'(top), 80'd0);
        chk("R12 init tags", 80'(tword), 80'hFFFF);
        chk("R12 init keeps data", ra_data, V_ONE);
        issue(4'd4, 3'd0, V_ZERO);
        look(3'd0, 3'd0, 3'd0);
        chk("R5 dec wraps", 80'(top), 80'd7);
        chk("R5 dec keeps tags", 80'(tword), 80'hFFFF);
        chk("R5 dec keeps data", ra_data, V_ONE);
        issue(4'd3, 3'd0, V_ZERO);
        chk("R5 inc wraps", 80'(top), 80'd0);
    endtask

    task automatic t_overflow_pop();
        issue(4'd9, 3'd0, V_ZERO);
        for (int k = 0; k < 8; k++) begin
            issue(4'd1, 3'd0, V_ONE | 80'(k));
        end
        look(3'd0, 3'd0, 3'd0);
        chk("R10 full top", 80'(top), 80'd0);
        issue(4'd1, 3'd0, V_W);
        look(3'd0, 3'd0, 3'd0);
        chk("R10 overflow flag", 80'(ovf), 80'd1);
        chk("R10 top kept", 80'(top), 80'd0);
        chk("R10 ST kept", ra_data, V_ONE | 80'd7);
        issue(4'd0, 3'd0, V_ZERO);
        chk("R10 flag pulse ends", 80'(ovf), 80'd0);
        issue(4'd2, 3'd0, V_ZERO);
        look(3'd7, 3'd0, 3'd0);
        chk("R4 pop top", 80'(top), 80'd1);
        chk("R4 pop tag", 80'(tword[1:0]), 80'd3);
        chk("R4 pop keeps data", ra_data, V_ONE | 80'd7);
        for (int k = 0; k < 7; k++) begin
            issue(4'd2, 3'd0, V_ZERO);
        end
        chk("R4 pops wrap", 80'(top), 80'd0);
        chk("R4 all empty", 80'(tword), 80'hFFFF);
        issue(4'd2, 3'd0, V_ZERO);
        chk("R11 pop empty unf", 80'(unf), 80'd1);
        chk("R11 pop empty top", 80'(top), 80'd0);
    endtask

    task automatic t_wrpop();
        issue(4'd9, 3'd0, V_ZERO);
        issue(4'd1, 3'd0, V_ONE);
        issue(4'd1, 3'd0, V_NEG);
        issue(4'd8, 3'd1, V_W);
        look(3'd0, 3'd0, 3'd0);
        chk("R9 top", 80'(top), 80'd7);
        chk("R9 result is ST", ra_data, V_W);
        chk("R9 tag", 80'(tq), 80'd0);
        chk("R9 popped slot empty", 80'(tword[13:12]), 80'd3);
        issue(4'd9, 3'd0, V_ZERO);
        issue(4'd8, 3'd1, V_W);
        chk("R11 wrpop empty unf", 80'(unf), 80'd1);
        chk("R11 wrpop empty tags", 80'(tword), 80'hFFFF);
    endtask

    task automatic t_illegal();
        issue(4'd9, 3'd0, V_ZERO);
        issue(4'd1, 3'd0, V_ONE);
        for (int c = 10; c < 16; c++) begin
            issue(4'(c), 3'd1, V_ZERO);
        end
        issue(4'd0, 3'd1, V_ZERO);
        look(3'd0, 3'd0, 3'd0);
        chk("R14 top", 80'(top), 80'd7);
        chk("R14 data", ra_data, V_ONE);
        chk("R14 tags", 80'(tword), 80'h3FFF);
        chk("R14 flags", 80'({ovf, unf}), 80'd0);
    endtask

    initial begin
        #(8 * 50000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_push();
        t_xchg_write_free();
        t_incdec_init();
        t_overflow_pop();
        t_wrpop();
        t_illegal();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule